// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Splitter

This block sits between a processor load/store unit and a memory port whose data width is not known in advance. It takes one byte, word (2 bytes) or longword (4 bytes) operand at any byte address. It then runs as few bus cycles as the responding port allows to move every byte of that operand. A single register holds the remaining byte count, and the address advances by the number of bytes each cycle actually moved.

The port reports its width on every acknowledge. The block uses that report to work out how many bytes the finished cycle carried. Write data is put on the bus before the width is known, so each byte sits in every lane where an 8-, 16- or 32-bit port would look for it. Read bytes are gathered into their big-endian operand positions and returned right-justified with a one-cycle done pulse. The number of bus cycles used is held on an output for checking.

Top module: `dbs_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_cyc`, `done` and `cycles` are 0.
- R2: A request is accepted at any byte address, with no alignment fault, and always ends with a `done` pulse.
- R3: The number of bus cycles is the minimum for the port width: one cycle for each group of operand bytes that lies inside one aligned port-width unit. A longword at a multiple of 4 on a 32-bit port takes 1 cycle. A word at an odd address on a 16-bit port takes 2 cycles.
- R4: Any longword on an 8-bit port takes 4 cycles.
- R5: A longword at an odd address on a 16-bit port takes 3 cycles. They move 1, 2 and 1 bytes at addresses a, a+1 and a+3, and `bus_len` shows 4, 3 and 1.
- R6: Port width code on `bus_psize`: 2'b00 is 32-bit, 2'b01 is 8-bit, 2'b10 is 16-bit. 2'b11 is treated as 32-bit.
- R7: Between two cycles of one operand, `bus_addr` grows by exactly the amount `bus_len` falls. `bus_len` is the count of bytes still to move. Operand size code on `req_size`: 2'b00 is byte, 2'b01 is word, 2'b10 and 2'b11 are longword.
- R8: Read data is big-endian. On a port of P bytes, the byte at address b arrives on lane b mod P, and lane i is `bus_rdata[31-8i -: 8]`. `rdata` holds the operand right-justified, with the byte at the lowest address most significant. Lanes the port does not use are ignored.
- R9: On a write, the byte for address b appears on lane b mod P for every port width P of 1, 2 and 4. Write data on `req_wdata` is right-justified and big-endian.
- R10: `done` rises in the cycle after the acknowledge that moves the last byte. It lasts exactly one cycle, `bus_cyc` is already 0 in that cycle, and `cycles` then holds the total for the operand.
- R11: While `bus_cyc` is 1 and `bus_ack` is 0, the cycle is held with `bus_addr` and `bus_len` unchanged.
- R12: While an operand is in progress, `req_ready` is 0 and a new `req_valid` is ignored. That request never starts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand request, taken when req_ready is 1 |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | 32 | Right-justified write operand |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Right-justified read operand, valid with done |
| cycles | output | 3 | Bus cycles used by the latest operand |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Address of the first byte of this cycle |
| bus_len | output | 3 | Operand bytes still to move |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_ack | input | 1 | Port acknowledges the cycle |
| bus_psize | input | 2 | Port width code, sampled with bus_ack |
| bus_rdata | input | 32 | Read lanes, sampled with bus_ack |

## Verification
The request is taken on the edge at which `req_valid` is seen. The first bus cycle is on the bus in the next cycle. Each acknowledge takes effect on its own edge, so the next address, or `done` with the assembled `rdata`, can be read one cycle later. The bench drives requests and acknowledges half a period before an edge and samples half a period after it. It logs the address and remaining count of every acknowledged cycle, checks `done` and `bus_cyc` in the cycle after the last acknowledge, and checks in the cycle after that that `done` has fallen. Write steering is judged by which memory bytes a width-aware port model changes, including the bytes on either side of the operand.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [1:0] {
        PW_32  = 2'b00,
        PW_8   = 2'b01,
        PW_16  = 2'b10,
        PW_RSV = 2'b11
    } port_w_e;

    typedef enum logic [1:0] {
        OP_BYTE  = 2'b00,
        OP_WORD  = 2'b01,
        OP_LONG  = 2'b10,
        OP_LONGX = 2'b11
    } op_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    // progress of one operand through the bus
    typedef struct packed {
        logic [2:0] total;   // operand bytes
        logic [2:0] left;    // bytes still to move
        logic [2:0] moved;   // bytes already moved
        logic [2:0] ncyc;    // bus cycles acknowledged
    } track_t;

    function automatic logic [2:0] port_bytes(input logic [1:0] code);
        case (port_w_e'(code))
            PW_8:    return 3'd1;
            PW_16:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] op_bytes(input logic [1:0] code);
        case (op_size_e'(code))
            OP_BYTE: return 3'd1;
            OP_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dbs_xfer_calc.sv
module dbs_xfer_calc
    import dbs_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  logic [2:0] left,
    input  logic [1:0] psize,
    output logic [2:0] step
);
    logic [2:0] pb;
    logic [2:0] room;

    always_comb begin
        pb   = port_bytes(psize);
        room = pb - ({1'b0, addr_lo} & (pb - 3'd1));
        step = (left < room) ? left : room;
    end

endmodule

// File: rtl/dbs_wr_steer.sv
module dbs_wr_steer
    import dbs_pkg::*;
(
    input  logic [1:0]        addr_lo,
    input  logic [2:0]        left,
    input  logic [2:0]        moved,
    input  logic [DATA_W-1:0] op,      // left-justified operand
    output logic [DATA_W-1:0] lanes
);
    logic [7:0] lane_b [LANES];

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        always_comb begin
            logic hit;
            int   pb;
            int   pos;
            int   delta;
            int   idx;
            hit       = 1'b0;
            lane_b[L] = 8'h00;
            pb        = 1;
            pos       = 0;
            delta     = 0;
            idx       = 0;
            // widest port first; the width choices never disagree on a lane
            for (int w = 2; w >= 0; w--) begin
                pb    = 1 << w;
                pos   = int'(addr_lo) % pb;
                delta = L - pos;
                if (!hit && (L < pb) && (delta >= 0) && (delta < int'(left))) begin
                    idx       = (int'(moved) + delta) % LANES;
                    hit       = 1'b1;
                    lane_b[L] = op[8*(LANES-1-idx) +: 8];
                end
            end
        end
        assign lanes[DATA_W-1-8*L -: 8] = lane_b[L];
    end

endmodule

// File: rtl/dbs_rd_merge.sv
module dbs_rd_merge
    import dbs_pkg::*;
(
    input  logic [1:0]        addr_lo,
    input  logic [2:0]        step,
    input  logic [2:0]        moved,
    input  logic [1:0]        psize,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] acc_in,    // left-justified partial operand
    output logic [DATA_W-1:0] acc_out
);
    always_comb begin
        int pb;
        int lane;
        int idx;
        pb      = int'(port_bytes(psize));
        lane    = 0;
        idx     = 0;
        acc_out = acc_in;
        for (int j = 0; j < LANES; j++) begin
            if (j < int'(step)) begin
                lane = (int'(addr_lo) + j) % pb;
                idx  = (int'(moved) + j) % LANES;
                acc_out[8*(LANES-1-idx) +: 8] = bus_rdata[8*(LANES-1-lane) +: 8];
            end
        end
    end

endmodule

// File: rtl/dbs_splitter.sv
module dbs_splitter
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              done,
    output logic [31:0]       rdata,
    output logic [2:0]        cycles,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_len,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [1:0]        bus_psize,
    input  logic [31:0]       bus_rdata
);
    state_e              state_q;
    track_t              trk_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                we_q;
    logic [DATA_W-1:0]   op_q;
    logic [DATA_W-1:0]   acc_q;
    logic [DATA_W-1:0]   acc_nxt;
    logic [DATA_W-1:0]   rdata_q;
    logic                done_q;
    logic [2:0]          step;
    logic [2:0]          req_n;
    logic                accept;
    logic                fire;
    logic                last;

    dbs_xfer_calc u_calc (
        .addr_lo (addr_q[1:0]),
        .left    (trk_q.left),
        .psize   (bus_psize),
        .step    (step)
    );

    dbs_wr_steer u_steer (
        .addr_lo (addr_q[1:0]),
        .left    (trk_q.left),
        .moved   (trk_q.moved),
        .op      (op_q),
        .lanes   (bus_wdata)
    );

    dbs_rd_merge u_merge (
        .addr_lo   (addr_q[1:0]),
        .step      (step),
        .moved     (trk_q.moved),
        .psize     (bus_psize),
        .bus_rdata (bus_rdata),
        .acc_in    (acc_q),
        .acc_out   (acc_nxt)
    );

    assign req_n  = op_bytes(req_size);
    assign accept = (state_q == ST_IDLE) && req_valid;
    assign fire   = (state_q == ST_RUN) && bus_ack;
    assign last   = fire && (trk_q.left == step);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            trk_q   <= '0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            op_q    <= '0;
            acc_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q     <= ST_RUN;
                addr_q      <= req_addr;
                we_q        <= req_write;
                op_q        <= req_wdata << (6'd32 - {req_n, 3'b000});
                acc_q       <= '0;
                trk_q.total <= req_n;
                trk_q.left  <= req_n;
                trk_q.moved <= 3'd0;
                trk_q.ncyc  <= 3'd0;
            end else if (fire) begin
                addr_q      <= addr_q + ADDR_W'(step);
                acc_q       <= acc_nxt;
                trk_q.left  <= trk_q.left - step;
                trk_q.moved <= trk_q.moved + step;
                trk_q.ncyc  <= trk_q.ncyc + 3'd1;
                if (last) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    rdata_q <= acc_nxt >> (6'd32 - {trk_q.total, 3'b000});
                end
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign bus_cyc   = (state_q == ST_RUN);
    assign bus_we    = bus_cyc && we_q;
    assign bus_addr  = addr_q;
    assign bus_len   = trk_q.left;
    assign done      = done_q;
    assign rdata     = rdata_q;
    assign cycles    = trk_q.ncyc;

endmodule

// File: rtl/dbs_splitter_chk.sv
module dbs_splitter_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              bus_cyc,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_len,
    input logic              done,
    input logic [2:0]        cycles
);
    // R11
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cyc && !bus_ack |=> bus_cyc && $stable(bus_addr) && $stable(bus_len));

    // R7
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cyc && $past(bus_cyc && bus_ack) |->
            (bus_addr - $past(bus_addr)) == ADDR_W'($past(bus_len) - bus_len));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_cyc && $past(bus_cyc && bus_ack));

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> (bus_len != 3'd0) && (bus_len <= 3'd4));

    // R3
    cycle_total_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles >= 3'd1) && (cycles <= 3'd4));

    // R12
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> !req_ready);

endmodule

bind dbs_splitter dbs_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .bus_cyc   (bus_cyc),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_len   (bus_len),
    .done      (done),
    .cycles    (cycles)
);

// File: tb/test_dbs_splitter.sv
module test_dbs_splitter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        bus_ack = 1'b0;
    logic [1:0]  bus_psize = 2'b00;
    logic [31:0] bus_rdata = '0;
    logic        req_ready, done, bus_cyc, bus_we;
    logic [31:0] rdata, bus_addr, bus_wdata;
    logic [2:0]  cycles, bus_len;

    logic [7:0]  mem [64];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          seq_addr [8];
    int          seq_len  [8];
    int          seq_n;
    logic [31:0] got_rdata;
    logic [2:0]  got_cycles;

    always #4 clk = ~clk;

    dbs_splitter i_dbs_splitter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .cycles(cycles),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr), .bus_len(bus_len),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_psize(bus_psize),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int pbytes(input logic [1:0] code);
        case (code)
            2'b01:   return 1;
            2'b10:   return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [31:0] mem_val(input int a, input int n);
        logic [31:0] v = '0;
        for (int i = 0; i < n; i++) v = (v << 8) | 32'(mem[a+i]);
        return v;
    endfunction

    // width-aware port model: answer the cycle now on the bus
    task automatic port_answer(input logic [1:0] pw);
        int p    = pbytes(pw);
        int a    = int'(bus_addr);
        int base = a - (a % p);
        int hi;
        bus_psize = pw;
        bus_rdata = 32'hEEEE_EEEE;
        for (int L = 0; L < p; L++) bus_rdata[31-8*L -: 8] = mem[base+L];
        if (bus_we) begin
            hi = (a % p) + int'(bus_len);
            if (hi > p) hi = p;
            for (int L = a % p; L < hi; L++) mem[base+L] = bus_wdata[31-8*L -: 8];
        end
    endtask

    task automatic run_op(input bit wr, input logic [1:0] sz, input int a,
                          input logic [31:0] wd, input logic [1:0] pw,
                          input int waits, input bit poke);
        int w = waits;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = 32'(a); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        seq_n = 0;
        for (int g = 0; g < 40; g++) begin
            if (done) break;
            if (bus_cyc) begin
                if (w > 0) begin
                    w--;
                    bus_ack = 1'b0;
                    if (poke) begin
                        req_valid = 1'b1; req_addr = 32'd50;
                        chk("R12 busy ready", 32'(req_ready), 32'd0);
                    end
                end else begin
                    if (seq_n < 8) begin
                        seq_addr[seq_n] = int'(bus_addr);
                        seq_len[seq_n]  = int'(bus_len);
                    end
                    seq_n++;
                    port_answer(pw);
                    bus_ack = 1'b1;
                end
            end
            @(negedge clk);
            bus_ack   = 1'b0;
            req_valid = 1'b0;
        end
        got_rdata  = rdata;
        got_cycles = cycles;
        chk("R10 done after last ack", 32'(done), 32'd1);
        chk("R10 bus idle at done", 32'(bus_cyc), 32'd0);
        chk("R10 cycles matches acks", 32'(got_cycles), 32'(seq_n));
        @(negedge clk);
        chk("R10 done one cycle", 32'(done), 32'd0);
        chk("R12 no stray transfer", 32'(bus_cyc), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 bus_cyc", 32'(bus_cyc), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 cycles", 32'(cycles), 32'd0);
    endtask

    task automatic t_aligned32;
        logic [31:0] e = mem_val(8, 4);
        run_op(1'b0, 2'b10, 8, '0, 2'b00, 0, 1'b0);
        chk("R3 aligned long 32-bit cycles", 32'(got_cycles), 32'd1);
        chk("R8 aligned long data", got_rdata, e);
    endtask

    task automatic t_odd8;
        logic [31:0] e = mem_val(9, 4);
        run_op(1'b0, 2'b10, 9, '0, 2'b01, 0, 1'b0);
        chk("R4 long 8-bit cycles", 32'(got_cycles), 32'd4);
        chk("R8 long 8-bit data", got_rdata, e);
        chk("R7 8-bit last addr", 32'(seq_addr[3]), 32'd12);
    endtask

    task automatic t_odd16;
        logic [31:0] e = mem_val(13, 4);
        run_op(1'b0, 2'b10, 13, '0, 2'b10, 0, 1'b0);
        chk("R5 odd long 16-bit cycles", 32'(got_cycles), 32'd3);
        chk("R5 addr0", 32'(seq_addr[0]), 32'd13);
        chk("R5 addr1", 32'(seq_addr[1]), 32'd14);
        chk("R5 addr2", 32'(seq_addr[2]), 32'd16);
        chk("R5 len0", 32'(seq_len[0]), 32'd4);
        chk("R5 len1", 32'(seq_len[1]), 32'd3);
        chk("R5 len2", 32'(seq_len[2]), 32'd1);
        chk("R8 odd long 16-bit data", got_rdata, e);
    endtask

    task automatic t_write(input int a, input logic [1:0] sz, input int n,
                           input logic [31:0] wd, input logic [1:0] pw, input int ecyc,
                           input string tag);
        logic [7:0] before_lo = mem[a-1];
        logic [7:0] before_hi = mem[a+n];
        logic [31:0] e = wd;
        if (n < 4) e = wd & ((32'd1 << (8*n)) - 1);
        run_op(1'b1, sz, a, wd, pw, 0, 1'b0);
        chk({tag, " R9 write bytes"}, mem_val(a, n), e);
        chk({tag, " R9 low neighbour"}, 32'(mem[a-1]), 32'(before_lo));
        chk({tag, " R9 high neighbour"}, 32'(mem[a+n]), 32'(before_hi));
        chk({tag, " R3 write cycles"}, 32'(got_cycles), 32'(ecyc));
    endtask

    task automatic t_byte_rsv;
        logic [31:0] e = mem_val(6, 1);
        run_op(1'b0, 2'b00, 6, '0, 2'b11, 0, 1'b0);
        chk("R6 code 11 as 32-bit cycles", 32'(got_cycles), 32'd1);
        chk("R8 byte data", got_rdata, e);
    endtask

    task automatic t_waits;
        logic [31:0] e = mem_val(2, 4);
        run_op(1'b0, 2'b10, 2, '0, 2'b00, 2, 1'b1);
        chk("R11 first addr after waits", 32'(seq_addr[0]), 32'd2);
        chk("R11 len after waits", 32'(seq_len[0]), 32'd4);
        chk("R3 split long 32-bit cycles", 32'(got_cycles), 32'd2);
        chk("R8 split long data", got_rdata, e);
        chk("R2 R7 second addr", 32'(seq_addr[1]), 32'd4);
    endtask

    task automatic t_roundtrip;
        run_op(1'b1, 2'b11, 35, 32'hC0DE_F00D, 2'b01, 0, 1'b0);
        chk("R4 write long 8-bit cycles", 32'(got_cycles), 32'd4);
        run_op(1'b0, 2'b11, 35, '0, 2'b10, 0, 1'b0);
        chk("R2 R8 read back 16-bit", got_rdata, 32'hC0DE_F00D);
        chk("R5 read back cycles", 32'(got_cycles), 32'd3);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_aligned32();
        t_odd8();
        t_odd16();
        t_write(21, 2'b10, 4, 32'h1122_3344, 2'b00, 2, "long32");
        t_write(31, 2'b01, 2, 32'h0000_A55A, 2'b10, 2, "word16");
        t_write(42, 2'b00, 1, 32'h0000_007E, 2'b10, 1, "byte16");
        t_byte_rsv();
        t_waits();
        t_roundtrip();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule